// File: doc/BRIEF.md
# Debug Breakpoint Priority Router

This block sits between the debug event sources of a processor subsystem and the two places a breakpoint can go: a debug-monitor entry request and a software-interrupt request. On every clock it looks at a co-processor software breakpoint, per-comparator trigger and tag hits, an external forced trigger, an external tag hit and a trace-complete indication. It picks the event with the highest priority. A four-bit configuration word (enable, monitor select, monitor enabled, monitor active) then decides where that breakpoint is delivered, if it is delivered at all.

Trace alignment decides when a breakpoint appears. An end-aligned trigger stops the trace and breaks at once. A begin-aligned or mid-aligned trigger arms the block, and the breakpoint is held back until the trace buffer reports that it is complete. A breakpoint that lands while the monitor is already running is kept pending and is replayed once the monitor exits. When a comparator tag hit and an external tag hit collide, the block resets the trigger sequencer and raises no breakpoint. All outputs are registered. Each one appears one clock after the inputs that cause it.

Top module: `bkpt_router`

## Requirements
- R1: A co-processor breakpoint (`cop_bkpt`) beats every other event and pulses `trace_stop`. It does not depend on `cfg_en`. It goes to `mon_req` when `cfg_mon_sel` and `cfg_mon_en` are both 1, and to `swi_req` otherwise.
- R2: With `cfg_en`=0, no event other than R1 produces `mon_req` or `swi_req`. `trace_stop` and `seq_rst` still follow their events.
- R3: With the configuration (en, sel, mon_en) = (1,0,0), breakpoints are sent to `swi_req`.
- R4: With the configuration (1,1,1,act=0), breakpoints are sent to `mon_req`. With act=1, no request is made and the breakpoint is held pending. The pending breakpoint is issued as `mon_req` in the first output cycle after `cfg_mon_act` falls, provided sel and mon_en are still both 1.
- R5: With the configuration (1,1,0,act=0), only end-aligned tag breakpoints reach `swi_req`. Begin-aligned, mid-aligned and forced breakpoints, and comparator breakpoints, are dropped.
- R6: Once a begin-aligned or mid-aligned trigger has armed the block, later `force_trig` pulses and comparator hits with break flag 0 have no effect. The breakpoint is issued when `trace_done` asserts, without a `trace_stop`. A comparator hit with break flag 1 ends the trace early with a breakpoint and `trace_stop`.
- R7: An external tag hit and any comparator tag hit in the same cycle pulse `seq_rst`. They drop any armed trace, and the tags raise no breakpoint.
- R8: Alignment field encoding: 00 = end, 01 = begin, 10 = mid, 11 = end. An external tag hit on its own always acts as end-aligned (immediate breakpoint and `trace_stop`), whatever the field holds.
- R9: `user_swi` is passed through to `swi_req`. When a `mon_req` is issued in the same cycle, `swi_req` stays 0.
- R10: `cfg_bad` is 1 when the configuration is (1,1,0,act=1) or (en=1, sel=0, mon_en=1). No breakpoint request is made in either case.
- R11: An end-aligned forced trigger, or comparator trigger, on an idle block breaks at once and pulses `trace_stop`.
- R12: Every output is 0 in the cycle after reset is sampled. Synchronous reset clears both the pending and the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cop_bkpt | input | 1 | Co-processor software breakpoint |
| cmp_hit | input | N_CMP | Comparator trigger hit, one bit per comparator |
| cmp_brk | input | N_CMP | Break flag of each comparator |
| cmp_tag | input | N_CMP | Comparator tag hit, one bit per comparator |
| ext_tag | input | 1 | External tag hit |
| force_trig | input | 1 | External forced trigger |
| trig_align | input | 2 | Trace alignment: 00 end, 01 begin, 10 mid, 11 end |
| trace_done | input | 1 | Trace buffer reports the session complete |
| user_swi | input | 1 | Software-interrupt request from user code |
| cfg_en | input | 1 | Breakpoint enable |
| cfg_mon_sel | input | 1 | Route breakpoints to the debug monitor |
| cfg_mon_en | input | 1 | Debug monitor enabled |
| cfg_mon_act | input | 1 | Debug monitor currently running |
| mon_req | output | 1 | One-cycle debug-monitor request |
| swi_req | output | 1 | One-cycle software-interrupt request |
| trace_stop | output | 1 | Pulse that terminates the trace session |
| seq_rst | output | 1 | Pulse that returns the trigger sequencer to its initial state |
| cfg_bad | output | 1 | Illegal configuration is present |

## Verification
A table of single-cycle vectors sweeps each configuration row against each event class: comparator break, forced trigger, comparator tag, external tag, tag collision, co-processor breakpoint and user interrupt. This separates routing faults from event-classification faults. Directed sequences then cover the stateful behaviour. Arming followed by ignored triggers and a completion shows whether the breakpoint is deferred. A breakpoint during an active monitor followed by its release shows whether the pending path replays it. Reset and collisions during an armed or pending state show that both kinds of state are cleared.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int ALIGN_W = 2;

    typedef enum logic [ALIGN_W-1:0] {
        AL_END     = 2'b00,
        AL_BEGIN   = 2'b01,
        AL_MID     = 2'b10,
        AL_END_ALT = 2'b11
    } align_e;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_SWI,
        RT_TAGSWI,
        RT_MON,
        RT_MON_BUSY
    } route_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TAG,
        EV_OTHER,
        EV_COP
    } ev_e;

    typedef struct packed {
        logic en;
        logic sel;
        logic mon_en;
        logic act;
    } cfg_t;

    typedef struct packed {
        ev_e  ev;
        logic stop;
        logic srst;
    } trig_t;

    function automatic logic align_is_end(logic [ALIGN_W-1:0] a);
        return !((a == AL_BEGIN) || (a == AL_MID));
    endfunction

    function automatic route_e decode_route(cfg_t c);
        route_e r;
        r = RT_NONE;
        if (c.en) begin
            unique case ({c.sel, c.mon_en})
                2'b00: r = RT_SWI;
                2'b01: r = RT_NONE;
                2'b10: r = c.act ? RT_NONE : RT_TAGSWI;
                2'b11: r = c.act ? RT_MON_BUSY : RT_MON;
                default: r = RT_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic cfg_is_bad(cfg_t c);
        return c.en && ((c.sel && !c.mon_en && c.act) || (!c.sel && c.mon_en));
    endfunction

endpackage

// File: rtl/bkpt_cfg_decode.sv
module bkpt_cfg_decode
    import bkpt_pkg::*;
(
    input  cfg_t   cfg,
    output route_e route,
    output logic   cop_to_mon,
    output logic   bad
);

    always_comb begin
        route      = decode_route(cfg);
        cop_to_mon = cfg.sel && cfg.mon_en;
        bad        = cfg_is_bad(cfg);
    end

endmodule

// File: rtl/bkpt_trig_ctl.sv
module bkpt_trig_ctl
    import bkpt_pkg::*;
#(
    parameter int N_CMP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cop_bkpt,
    input  logic [N_CMP-1:0]   cmp_hit,
    input  logic [N_CMP-1:0]   cmp_brk,
    input  logic [N_CMP-1:0]   cmp_tag,
    input  logic               ext_tag,
    input  logic               force_trig,
    input  logic [ALIGN_W-1:0] trig_align,
    input  logic               trace_done,
    output trig_t              tr
);

    logic [N_CMP-1:0] brk_vec;
    logic             armed_q, armed_d;
    logic             tag_any, hit_any, brk_any, coll, end_al;

    for (genvar g = 0; g < N_CMP; g++) begin : g_brk
        assign brk_vec[g] = cmp_hit[g] & cmp_brk[g];
    end

    assign tag_any = |cmp_tag;
    assign hit_any = |cmp_hit;
    assign brk_any = |brk_vec;
    assign coll    = ext_tag & tag_any;
    assign end_al  = align_is_end(trig_align);

    always_comb begin
        tr      = '{ev: EV_NONE, stop: 1'b0, srst: coll};
        armed_d = armed_q;
        if (cop_bkpt) begin
            tr.ev   = EV_COP;
            tr.stop = 1'b1;
            armed_d = 1'b0;
        end else if (coll) begin
            armed_d = 1'b0;
        end else if (ext_tag) begin
            tr.ev   = EV_TAG;
            tr.stop = 1'b1;
            armed_d = 1'b0;
        end else if (tag_any) begin
            if (end_al) begin
                tr.ev   = EV_TAG;
                tr.stop = 1'b1;
                armed_d = 1'b0;
            end else if (!armed_q) begin
                armed_d = 1'b1;
            end
        end else if (armed_q) begin
            if (trace_done) begin
                tr.ev   = EV_OTHER;
                armed_d = 1'b0;
            end else if (brk_any) begin
                tr.ev   = EV_OTHER;
                tr.stop = 1'b1;
                armed_d = 1'b0;
            end
        end else if (force_trig || hit_any) begin
            if (end_al) begin
                tr.ev   = EV_OTHER;
                tr.stop = 1'b1;
            end else begin
                armed_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end

endmodule

// File: rtl/bkpt_issue.sv
module bkpt_issue
    import bkpt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  trig_t  tr,
    input  route_e route,
    input  logic   cop_to_mon,
    input  logic   mon_act,
    input  logic   bad_in,
    input  logic   user_swi,
    output logic   mon_req,
    output logic   swi_req,
    output logic   trace_stop,
    output logic   seq_rst,
    output logic   cfg_bad
);

    logic pend_q, pend_d, pend_set;
    logic mon_new, swi_new, mon_d, swi_d, release_ok;

    always_comb begin
        mon_new  = 1'b0;
        swi_new  = 1'b0;
        pend_set = 1'b0;
        if (tr.ev == EV_COP) begin
            if (cop_to_mon) begin
                if (mon_act) pend_set = 1'b1;
                else         mon_new  = 1'b1;
            end else begin
                swi_new = 1'b1;
            end
        end else if (tr.ev != EV_NONE) begin
            unique case (route)
                RT_SWI:      swi_new  = 1'b1;
                RT_TAGSWI:   swi_new  = (tr.ev == EV_TAG);
                RT_MON:      mon_new  = 1'b1;
                RT_MON_BUSY: pend_set = 1'b1;
                default:     ;
            endcase
        end
        release_ok = pend_q && cop_to_mon && !mon_act;
        mon_d      = mon_new || release_ok;
        swi_d      = (swi_new || user_swi) && !mon_d;
        pend_d     = cop_to_mon && (pend_set || (pend_q && mon_act));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            mon_req    <= 1'b0;
            swi_req    <= 1'b0;
            trace_stop <= 1'b0;
            seq_rst    <= 1'b0;
            cfg_bad    <= 1'b0;
        end else begin
            pend_q     <= pend_d;
            mon_req    <= mon_d;
            swi_req    <= swi_d;
            trace_stop <= tr.stop;
            seq_rst    <= tr.srst;
            cfg_bad    <= bad_in;
        end
    end

endmodule

// File: rtl/bkpt_router.sv
module bkpt_router
    import bkpt_pkg::*;
#(
    parameter int N_CMP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cop_bkpt,
    input  logic [N_CMP-1:0]   cmp_hit,
    input  logic [N_CMP-1:0]   cmp_brk,
    input  logic [N_CMP-1:0]   cmp_tag,
    input  logic               ext_tag,
    input  logic               force_trig,
    input  logic [ALIGN_W-1:0] trig_align,
    input  logic               trace_done,
    input  logic               user_swi,
    input  logic               cfg_en,
    input  logic               cfg_mon_sel,
    input  logic               cfg_mon_en,
    input  logic               cfg_mon_act,
    output logic               mon_req,
    output logic               swi_req,
    output logic               trace_stop,
    output logic               seq_rst,
    output logic               cfg_bad
);

    cfg_t   cfg;
    route_e route;
    logic   cop_to_mon, bad_c;
    trig_t  tr;

    assign cfg = '{en: cfg_en, sel: cfg_mon_sel, mon_en: cfg_mon_en, act: cfg_mon_act};

    bkpt_cfg_decode u_dec (
        .cfg        (cfg),
        .route      (route),
        .cop_to_mon (cop_to_mon),
        .bad        (bad_c)
    );

    bkpt_trig_ctl #(.N_CMP(N_CMP)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .cop_bkpt   (cop_bkpt),
        .cmp_hit    (cmp_hit),
        .cmp_brk    (cmp_brk),
        .cmp_tag    (cmp_tag),
        .ext_tag    (ext_tag),
        .force_trig (force_trig),
        .trig_align (trig_align),
        .trace_done (trace_done),
        .tr         (tr)
    );

    bkpt_issue u_iss (
        .clk        (clk),
        .rst        (rst),
        .tr         (tr),
        .route      (route),
        .cop_to_mon (cop_to_mon),
        .mon_act    (cfg_mon_act),
        .bad_in     (bad_c),
        .user_swi   (user_swi),
        .mon_req    (mon_req),
        .swi_req    (swi_req),
        .trace_stop (trace_stop),
        .seq_rst    (seq_rst),
        .cfg_bad    (cfg_bad)
    );

endmodule

// File: rtl/bkpt_router_chk.sv
module bkpt_router_chk #(
    parameter int N_CMP = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cop_bkpt,
    input logic [N_CMP-1:0] cmp_tag,
    input logic             ext_tag,
    input logic             user_swi,
    input logic             cfg_en,
    input logic             cfg_mon_sel,
    input logic             cfg_mon_en,
    input logic             cfg_mon_act,
    input logic             mon_req,
    input logic             swi_req,
    input logic             trace_stop,
    input logic             seq_rst,
    input logic             cfg_bad
);

    assert_cop_stop_R1: assert property (@(posedge clk) disable iff (rst)
        cop_bkpt |=> trace_stop);

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !cop_bkpt && !user_swi && !cfg_mon_en) |=> (!mon_req && !swi_req));

    assert_busy_no_mon_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_mon_act |=> !mon_req);

    assert_collision_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (ext_tag && (|cmp_tag)) |=> seq_rst);

    assert_mon_over_swi_R9: assert property (@(posedge clk) disable iff (rst)
        !(mon_req && swi_req));

    assert_bad_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mon_sel && !cfg_mon_en && cfg_mon_act) |=> cfg_bad);

    assert_reset_quiet_R12: assert property (@(posedge clk)
        rst |=> (!mon_req && !swi_req && !trace_stop && !seq_rst && !cfg_bad));

endmodule

bind bkpt_router bkpt_router_chk #(.N_CMP(N_CMP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cop_bkpt    (cop_bkpt),
    .cmp_tag     (cmp_tag),
    .ext_tag     (ext_tag),
    .user_swi    (user_swi),
    .cfg_en      (cfg_en),
    .cfg_mon_sel (cfg_mon_sel),
    .cfg_mon_en  (cfg_mon_en),
    .cfg_mon_act (cfg_mon_act),
    .mon_req     (mon_req),
    .swi_req     (swi_req),
    .trace_stop  (trace_stop),
    .seq_rst     (seq_rst),
    .cfg_bad     (cfg_bad)
);

// File: tb/test_bkpt_router.sv
module test_bkpt_router;

    localparam int N_CMP = 4;
    localparam int NV    = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cop_bkpt = 1'b0, ext_tag = 1'b0, force_trig = 1'b0;
    logic             trace_done = 1'b0, user_swi = 1'b0;
    logic [N_CMP-1:0] cmp_hit = '0, cmp_brk = '0, cmp_tag = '0;
    logic [1:0]       trig_align = 2'b00;
    logic             cfg_en = 1'b0, cfg_mon_sel = 1'b0, cfg_mon_en = 1'b0, cfg_mon_act = 1'b0;
    logic             mon_req, swi_req, trace_stop, seq_rst, cfg_bad;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    bkpt_router #(.N_CMP(N_CMP)) i_bkpt_router (
        .clk(clk), .rst(rst), .cop_bkpt(cop_bkpt), .cmp_hit(cmp_hit), .cmp_brk(cmp_brk),
        .cmp_tag(cmp_tag), .ext_tag(ext_tag), .force_trig(force_trig), .trig_align(trig_align),
        .trace_done(trace_done), .user_swi(user_swi), .cfg_en(cfg_en), .cfg_mon_sel(cfg_mon_sel),
        .cfg_mon_en(cfg_mon_en), .cfg_mon_act(cfg_mon_act), .mon_req(mon_req), .swi_req(swi_req),
        .trace_stop(trace_stop), .seq_rst(seq_rst), .cfg_bad(cfg_bad)
    );

    // layout: cfg{en,sel,mon_en,act} | cop etag ctag chit cbrk frc | align | uswi | exp{mon,swi,stop,srst,bad}
    localparam logic [17:0] VEC [0:NV-1] = '{
        {4'b1000, 6'b000110, 2'b00, 1'b0, 5'b01100},  // R3 comparator break to SWI
        {4'b0000, 6'b000110, 2'b00, 1'b0, 5'b00100},  // R2 disabled
        {4'b1110, 6'b000110, 2'b00, 1'b0, 5'b10100},  // R4 monitor route
        {4'b1111, 6'b000110, 2'b00, 1'b0, 5'b00100},  // R4 monitor busy
        {4'b1100, 6'b000110, 2'b00, 1'b0, 5'b00100},  // R5 non-tag dropped
        {4'b1100, 6'b010000, 2'b00, 1'b0, 5'b01100},  // R5 external tag passes
        {4'b1100, 6'b001000, 2'b00, 1'b0, 5'b01100},  // R5 end-aligned comparator tag passes
        {4'b1000, 6'b011000, 2'b00, 1'b0, 5'b00010},  // R7 collision
        {4'b1000, 6'b010000, 2'b01, 1'b0, 5'b01100},  // R8 ext tag with begin field
        {4'b1000, 6'b010000, 2'b10, 1'b0, 5'b01100},  // R8 ext tag with mid field
        {4'b1101, 6'b000000, 2'b00, 1'b0, 5'b00001},  // R10 sel,!mon_en,act
        {4'b1010, 6'b000000, 2'b00, 1'b0, 5'b00001},  // R10 !sel,mon_en
        {4'b1110, 6'b000110, 2'b00, 1'b1, 5'b10100},  // R9 monitor beats user swi
        {4'b1000, 6'b000000, 2'b00, 1'b1, 5'b01000},  // R9 user swi passes
        {4'b0000, 6'b100000, 2'b00, 1'b0, 5'b01100},  // R1 cop ignores enable
        {4'b0110, 6'b100000, 2'b00, 1'b0, 5'b10100},  // R1 cop to monitor
        {4'b1110, 6'b111000, 2'b00, 1'b0, 5'b10110},  // R1 cop beats collision
        {4'b1000, 6'b000001, 2'b00, 1'b0, 5'b01100},  // R11 forced end-aligned
        {4'b1000, 6'b000001, 2'b11, 1'b0, 5'b01100},  // R11 align 11 is end
        {4'b1010, 6'b000110, 2'b00, 1'b0, 5'b00101},  // R10 no request in bad cfg
        {4'b1100, 6'b100000, 2'b00, 1'b0, 5'b01100},  // R1 cop in tag-only cfg to swi
        {4'b1101, 6'b010000, 2'b00, 1'b0, 5'b00101}   // R10 ext tag dropped in bad cfg
    };

    function automatic logic [4:0] outs();
        return {mon_req, swi_req, trace_stop, seq_rst, cfg_bad};
    endfunction

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = outs();
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b expected=%b (mon,swi,stop,srst,bad)", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in();
        cop_bkpt = 0; ext_tag = 0; force_trig = 0; trace_done = 0; user_swi = 0;
        cmp_hit = '0; cmp_brk = '0; cmp_tag = '0; trig_align = 2'b00;
    endtask

    task automatic set_cfg(input logic [3:0] c);
        {cfg_en, cfg_mon_sel, cfg_mon_en, cfg_mon_act} = c;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R12 reset state", 5'b00000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            do_reset();
            set_cfg(v[17:14]);
            cop_bkpt = v[13];
            ext_tag  = v[12];
            cmp_tag[i % N_CMP] = v[11];
            cmp_hit[i % N_CMP] = v[10];
            cmp_brk[i % N_CMP] = v[9];
            force_trig = v[8];
            trig_align = v[7:6];
            user_swi   = v[5];
            tick();
            chk($sformatf("table vector %0d", i), v[4:0]);
            idle_in();
        end

        // R6: begin-aligned arm, ignored triggers, completion
        do_reset(); set_cfg(4'b1000);
        force_trig = 1; trig_align = 2'b01; tick(); idle_in();
        chk("R6 arm gives no output", 5'b00000);
        trig_align = 2'b01; force_trig = 1; tick(); idle_in();
        chk("R6 later forced trigger ignored", 5'b00000);
        trig_align = 2'b01; cmp_hit[1] = 1; tick(); idle_in();
        chk("R6 brk=0 comparator ignored", 5'b00000);
        trace_done = 1; tick(); idle_in();
        chk("R6 breakpoint on trace done", 5'b01000);
        trace_done = 1; tick(); idle_in();
        chk("R6 disarmed after completion", 5'b00000);

        // R6: mid-aligned, break-flagged comparator ends early
        do_reset(); set_cfg(4'b1000);
        cmp_hit[2] = 1; trig_align = 2'b10; tick(); idle_in();
        chk("R6 mid arm", 5'b00000);
        trig_align = 2'b10; cmp_hit[3] = 1; cmp_brk[3] = 1; tick(); idle_in();
        chk("R6 brk=1 comparator ends trace", 5'b01100);

        // R5: deferred begin-aligned breakpoint dropped in tag-only cfg
        do_reset(); set_cfg(4'b1100);
        force_trig = 1; trig_align = 2'b01; tick(); idle_in();
        trace_done = 1; tick(); idle_in();
        chk("R5 begin-aligned completion suppressed", 5'b00000);

        // R4: pending replay
        do_reset(); set_cfg(4'b1111);
        cmp_hit[0] = 1; cmp_brk[0] = 1; tick(); idle_in();
        chk("R4 busy breakpoint held", 5'b00100);
        tick();
        chk("R4 still held while active", 5'b00000);
        set_cfg(4'b1110); tick();
        chk("R4 replay after monitor exit", 5'b10000);
        tick();
        chk("R4 replay is single cycle", 5'b00000);

        // R12: reset clears pending
        set_cfg(4'b1111);
        ext_tag = 1; tick(); idle_in();
        do_reset(); set_cfg(4'b1110); tick();
        chk("R12 reset clears pending", 5'b00000);

        // R12: reset clears armed state
        do_reset(); set_cfg(4'b1000);
        force_trig = 1; trig_align = 2'b01; tick(); idle_in();
        do_reset();
        trace_done = 1; tick(); idle_in();
        chk("R12 reset clears armed", 5'b00000);

        // R7: collision drops armed trace
        do_reset(); set_cfg(4'b1000);
        force_trig = 1; trig_align = 2'b01; tick(); idle_in();
        ext_tag = 1; cmp_tag[2] = 1; tick(); idle_in();
        chk("R7 collision pulses seq_rst", 5'b00010);
        trace_done = 1; tick(); idle_in();
        chk("R7 collision disarmed trace", 5'b00000);

        summary();
    end

endmodule